// File: doc/BRIEF.md
# Eight-bit GPIO port with atomic set and clear

This block is a general-purpose I/O port with one register bus. Each pin has a data latch bit and a direction bit. The direction bit decides two things for its pin: whether the output driver is enabled, and what a read of the data register returns for that bit. With the bit at 1, the driver is on and the read returns the latch bit. With the bit at 0, the driver is off and the read returns the pin level after it has passed through a synchronizer.

Software can change the latch in two ways:
- A plain write to the data register replaces the whole latch.
- A write to one of two write-only strobe registers forces selected latch bits to 1 or to 0 and leaves the other bits alone. No read-modify-write sequence is needed.

Every bus access completes in a single cycle. Read data is registered, so it appears on the bus one cycle after the access.

Top module: `gpio_setclr_port`

## Requirements
- R1: After reset the direction register, the data latch, `pin_oe`, `pin_out` and `bus_rdata` are all zero, so every pin starts as an input.
- R2: The register map is fixed: data at address 0, direction at address 1, set strobe at address 2 and clear strobe at address 3. A write to address 1 loads the direction register. It shows on `pin_oe` after the write edge, and a read of address 1 returns it.
- R3: A write to address 0 loads all latch bits at once. `pin_out` always shows the latch.
- R4: A write to address 2 sets every latch bit whose data bit is 1 and leaves every latch bit whose data bit is 0 unchanged.
- R5: A write to address 3 clears every latch bit whose data bit is 1 and leaves every latch bit whose data bit is 0 unchanged.
- R6: Reads of addresses 2 and 3 return zero. The strobe writes keep no state of their own.
- R7: A read of address 0 returns, for each bit, the latch bit where the direction bit is 1 and the synchronized pin level where the direction bit is 0.
- R8: Pin inputs pass through two flops. A pin change made before edge k is invisible to a read accepted at edges k and k+1, and is returned by a read accepted at edge k+2.
- R9: Read data is registered. It appears on `bus_rdata` in the cycle after the accepted read and is zero in any cycle that follows no read.
- R10: Only a write changes `pin_out` or `pin_oe`. Reads and idle cycles leave both stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Raw pin levels, asynchronous |
| pin_oe | output | 8 | Per-pin output driver enable |
| pin_out | output | 8 | Per-pin output value |

## Verification
The bench builds the port with its default width of 8 and with two synchronizer stages. At these values the full-width cases can be reached directly: all-ones and all-zeros strobes, and alternating masks. The bench also covers mixed direction patterns, where one data read returns latch bits and pin bits together. Two stages keep the synchronizer delay short enough to count exactly: the bench issues reads on back-to-back cycles after a pin change and checks on which cycle the new level first appears.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;

    localparam int REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_SET  = 2'd2,
        REG_CLR  = 2'd3
    } gpio_reg_e;

endpackage

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync #(
    parameter int PORT_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pin_raw,
    output logic [PORT_W-1:0] pin_sync
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [PORT_W-1:0] stg_d [SYNC_STAGES];
    logic [PORT_W-1:0] stg_q [SYNC_STAGES];

    always_comb begin
        stg_d[0] = pin_raw;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q[g] <= '0;
            end else begin
                stg_q[g] <= stg_d[g];
            end
        end
    end

    assign pin_sync = stg_q[LAST];

endmodule

// File: rtl/gpio_sc_regs.sv
module gpio_sc_regs
    import gpio_sc_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  gpio_reg_e         wr_addr,
    input  logic [PORT_W-1:0] wr_data,
    output logic [PORT_W-1:0] latch,
    output logic [PORT_W-1:0] dir
);

    typedef struct packed {
        logic [PORT_W-1:0] data;
        logic [PORT_W-1:0] dir;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_addr)
                REG_DATA: st_d.data = wr_data;
                REG_DIR:  st_d.dir  = wr_data;
                REG_SET:  st_d.data = st_q.data | wr_data;
                REG_CLR:  st_d.data = st_q.data & ~wr_data;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign latch = st_q.data;
    assign dir   = st_q.dir;

endmodule

// File: rtl/gpio_sc_rdmux.sv
module gpio_sc_rdmux
    import gpio_sc_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  gpio_reg_e         rd_addr,
    input  logic [PORT_W-1:0] latch,
    input  logic [PORT_W-1:0] dir,
    input  logic [PORT_W-1:0] pin_sync,
    output logic [PORT_W-1:0] rdata
);

    typedef struct packed {
        logic [PORT_W-1:0] rdata;
    } rd_t;

    rd_t st_d, st_q;

    always_comb begin
        st_d.rdata = '0;
        if (rd_en) begin
            case (rd_addr)
                REG_DATA: st_d.rdata = (dir & latch) | (~dir & pin_sync);
                REG_DIR:  st_d.rdata = dir;
                REG_SET:  st_d.rdata = '0;
                REG_CLR:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;

endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
    import gpio_sc_pkg::*;
#(
    parameter int PORT_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_we,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [PORT_W-1:0]     bus_wdata,
    output logic [PORT_W-1:0]     bus_rdata,
    input  logic [PORT_W-1:0]     pin_in,
    output logic [PORT_W-1:0]     pin_oe,
    output logic [PORT_W-1:0]     pin_out
);

    logic              wr_en;
    logic              rd_en;
    gpio_reg_e         reg_sel;
    logic [PORT_W-1:0] latch;
    logic [PORT_W-1:0] dir;
    logic [PORT_W-1:0] pin_sync;

    assign wr_en   = bus_sel & bus_we;
    assign rd_en   = bus_sel & ~bus_we;
    assign reg_sel = gpio_reg_e'(bus_addr);

    gpio_sc_sync #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (pin_in),
        .pin_sync (pin_sync)
    );

    gpio_sc_regs #(.PORT_W(PORT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (reg_sel),
        .wr_data (bus_wdata),
        .latch   (latch),
        .dir     (dir)
    );

    gpio_sc_rdmux #(.PORT_W(PORT_W)) u_rdmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_addr  (reg_sel),
        .latch    (latch),
        .dir      (dir),
        .pin_sync (pin_sync),
        .rdata    (bus_rdata)
    );

    assign pin_oe  = dir;
    assign pin_out = latch;

endmodule

// File: rtl/gpio_setclr_port_chk.sv
module gpio_setclr_port_chk #(
    parameter int PORT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [1:0]        bus_addr,
    input logic [PORT_W-1:0] bus_wdata,
    input logic [PORT_W-1:0] bus_rdata,
    input logic [PORT_W-1:0] pin_oe,
    input logic [PORT_W-1:0] pin_out
);

    logic wr, rd;
    assign wr = bus_sel & bus_we;
    assign rd = bus_sel & ~bus_we;

    assert_dir_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == 2'd1) |=> (pin_oe == $past(bus_wdata)));

    assert_data_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == 2'd0) |=> (pin_out == $past(bus_wdata)));

    assert_set_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == 2'd2) |=> (pin_out == ($past(pin_out) | $past(bus_wdata))));

    assert_clear_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == 2'd3) |=> (pin_out == ($past(pin_out) & ~$past(bus_wdata))));

    assert_strobe_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr[1]) |=> (bus_rdata == '0));

    assert_out_bits_read_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == 2'd0) |=> ((bus_rdata & $past(pin_oe)) == ($past(pin_out) & $past(pin_oe))));

    assert_idle_rdata_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (bus_rdata == '0));

    assert_outputs_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

bind gpio_setclr_port gpio_setclr_port_chk #(.PORT_W(PORT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out)
);

// File: tb/gpio_setclr_port_tb.sv
`timescale 1ns/1ps
module gpio_setclr_port_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0;
    logic         bus_we = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pin_in = 8'hA5;
    logic [W-1:0] pin_oe;
    logic [W-1:0] pin_out;

    int checks = 0;
    int failures = 0;
    logic [W-1:0] m_data = '0;
    logic [W-1:0] m_dir = '0;

    always #2 clk = ~clk;

    gpio_setclr_port #(.PORT_W(W), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        case (a)
            2'd0: m_data = d;
            2'd1: m_dir = d;
            2'd2: m_data = m_data | d;
            default: m_data = m_data & ~d;
        endcase
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [W-1:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic logic [W-1:0] exp_data();
        return (m_dir & m_data) | (~m_dir & pin_in);
    endfunction

    task automatic t_reset();
        logic [W-1:0] r;
        chk("R1 pin_oe after reset", pin_oe, '0);
        chk("R1 pin_out after reset", pin_out, '0);
        chk("R1 rdata after reset", bus_rdata, '0);
        bus_read(2'd1, r);
        chk("R1 dir reads zero", r, '0);
        bus_read(2'd0, r);
        chk("R1 all pins inputs, data read returns pins", r, 8'hA5);
    endtask

    task automatic t_dir();
        logic [W-1:0] r;
        bus_write(2'd1, 8'h3C);
        chk("R2 pin_oe after dir write", pin_oe, 8'h3C);
        bus_read(2'd1, r);
        chk("R2 dir readback", r, 8'h3C);
    endtask

    task automatic t_data_write();
        bus_write(2'd0, 8'h96);
        chk("R3 pin_out after data write", pin_out, 8'h96);
        bus_write(2'd0, 8'h00);
        chk("R3 pin_out after clearing write", pin_out, 8'h00);
    endtask

    task automatic t_set();
        bus_write(2'd0, 8'h81);
        bus_write(2'd2, 8'h0C);
        chk("R4 set merges bits", pin_out, 8'h8D);
        bus_write(2'd2, 8'h00);
        chk("R4 zero set no effect", pin_out, 8'h8D);
        bus_write(2'd2, 8'hFF);
        chk("R4 set all", pin_out, 8'hFF);
    endtask

    task automatic t_clear();
        bus_write(2'd3, 8'hA0);
        chk("R5 clear selected bits", pin_out, 8'h5F);
        bus_write(2'd3, 8'h00);
        chk("R5 zero clear no effect", pin_out, 8'h5F);
        bus_write(2'd3, 8'hFF);
        chk("R5 clear all", pin_out, 8'h00);
    endtask

    task automatic t_strobe_reads();
        logic [W-1:0] r;
        bus_write(2'd0, 8'h5A);
        bus_write(2'd2, 8'hF0);
        bus_read(2'd2, r);
        chk("R6 set address reads zero", r, '0);
        bus_write(2'd3, 8'h0F);
        bus_read(2'd3, r);
        chk("R6 clear address reads zero", r, '0);
        chk("R6 latch holds only strobe effect", pin_out, m_data);
    endtask

    task automatic t_mixed_read();
        logic [W-1:0] r;
        pin_in = 8'h33;
        repeat (3) @(negedge clk);
        bus_write(2'd1, 8'hF0);
        bus_write(2'd0, 8'hA5);
        bus_read(2'd0, r);
        chk("R7 mixed direction read", r, exp_data());
        bus_write(2'd1, 8'h0F);
        bus_read(2'd0, r);
        chk("R7 inverted direction read", r, exp_data());
        bus_write(2'd1, 8'hFF);
        bus_read(2'd0, r);
        chk("R7 all outputs read latch", r, 8'hA5);
    endtask

    task automatic t_sync_latency();
        logic [W-1:0] r1, r2, r3;
        bus_write(2'd1, 8'h00);
        pin_in = 8'h11;
        repeat (4) @(negedge clk);
        pin_in = 8'hEE;
        bus_read(2'd0, r1);
        bus_read(2'd0, r2);
        bus_read(2'd0, r3);
        chk("R8 first read old level", r1, 8'h11);
        chk("R8 second read old level", r2, 8'h11);
        chk("R8 third read new level", r3, 8'hEE);
    endtask

    task automatic t_idle_and_stable();
        logic [W-1:0] r;
        logic [W-1:0] o, e;
        bus_write(2'd1, 8'hC3);
        bus_write(2'd0, 8'h7E);
        bus_read(2'd1, r);
        chk("R9 read data one cycle after read", r, 8'hC3);
        o = pin_out; e = pin_oe;
        @(negedge clk);
        chk("R9 rdata zero after idle cycle", bus_rdata, '0);
        bus_read(2'd0, r);
        repeat (2) @(negedge clk);
        chk("R10 pin_out stable without write", pin_out, o);
        chk("R10 pin_oe stable without write", pin_oe, e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_dir();
        t_data_write();
        t_set();
        t_clear();
        t_strobe_reads();
        t_mixed_read();
        t_sync_latency();
        t_idle_and_stable();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule